// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block decides when a 12-bit successive-approximation converter tracks its input and when it converts, and it drives the single status pin that tells the host what is happening. All logic runs on one system clock. The conversion clock is a one-cycle enable that comes from one of two places. It can be an internal oscillator tick, or it can be produced on every second rising edge of the serial clock, so the conversion clock runs at half the serial rate.

Conversions are triggered in one of two ways. In manual mode, an active-low start input, seen low on a conversion-clock tick after the acquisition window, begins a conversion. In automatic mode, a new conversion begins on its own once the acquisition window after the previous one has run out. The converter's bit-decision logic is not part of this block. A fixed-length conversion counter takes its place, and the result word offered on `result_in` is captured when that counter ends. The status pin acts either as a busy flag or as a latched "result ready" interrupt, and its active level can be set to high or low.

Top module: `sar_seq_top`

## Requirements
- R1: A conversion keeps `convert_en` high for exactly 18 conversion-clock ticks, and the block then returns to sampling.
- R2: `sample_en` stays high for at least 3 conversion-clock ticks before any conversion begins, counting the tick that starts the conversion.
- R3: With `auto_mode`=0, a conversion begins only on a tick where `start_n` is low and the acquisition window has been met. While `start_n` is high the block keeps sampling.
- R4: With `auto_mode`=1, a conversion begins on the 3rd tick after the previous conversion ended, or after reset, with no start input needed.
- R5: With `clk_src_sel`=1, a tick occurs on every second rising edge of `sclk`, and `osc_tick` is ignored. With `clk_src_sel`=0, every `osc_tick` pulse is a tick.
- R6: With `stat_int_mode`=0, the status pin is at its active level exactly while `convert_en` is high.
- R7: With `stat_int_mode`=1, the status pin goes active in the cycle a conversion ends. It stays active until cleared, and it is inactive while a conversion runs if no earlier result is pending.
- R8: A falling edge of `cs_n` clears a pending interrupt, so the status pin is inactive in the cycle after `cs_n` is first seen low.
- R9: `stat_act_high`=0 makes the active level 0 (the default), and `stat_act_high`=1 makes it 1. The inactive level is always the opposite.
- R10: A start request that arrives during a conversion is ignored. The running conversion still lasts 18 ticks and is not restarted.
- R11: A one-cycle `soft_rst` returns the block to sampling with a fresh acquisition window and a fresh serial divider phase. It also clears any pending interrupt, so the status pin is inactive in the next cycle.
- R12: `result_o` takes the value of `result_in` at the tick that ends a conversion, and holds that value until the next conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset |
| clk_src_sel | input | 1 | 0: oscillator tick, 1: serial clock divided by two |
| osc_tick | input | 1 | One-cycle internal oscillator tick |
| sclk | input | 1 | Serial clock level, synchronous to `clk` |
| auto_mode | input | 1 | 1: free-running re-trigger, 0: start-input trigger |
| start_n | input | 1 | Active-low conversion start |
| stat_int_mode | input | 1 | 0: busy flag, 1: latched interrupt |
| stat_act_high | input | 1 | Active level of the status pin |
| cs_n | input | 1 | Active-low chip select, whose fall starts a read frame |
| result_in | input | 12 | Result word offered at the end of a conversion |
| sample_en | output | 1 | Sample/hold tracking enable |
| convert_en | output | 1 | Conversion in progress |
| status_o | output | 1 | Status pin |
| result_o | output | 12 | Last captured result |

## Verification
Each tick, each `soft_rst` pulse and each `cs_n` fall takes effect at the next rising edge of `clk`, with one register stage. So `sample_en`, `convert_en`, `status_o` and `result_o` hold their new value one cycle after the input was presented. A serial tick appears only on the second `sclk` rise. The bench drives every input at a falling edge and holds it across exactly one rising edge. It then reads the outputs at the following falling edge, which keeps every check one register stage after its stimulus. Tick counts, such as the 3rd acquisition tick and the 18th conversion tick, are counted in the bench from the requirements and are never taken from inside the design.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

  typedef enum logic {
    PH_ACQ  = 1'b0,
    PH_CONV = 1'b1
  } seq_phase_e;

  // Acquisition window is met when the ticks already seen plus the current one reach the minimum.
  function automatic logic window_met(input int unsigned seen, input int unsigned need);
    return (seen + 1) >= need;
  endfunction

  // Electrical level of the status pin for a logical active/inactive state.
  function automatic logic pin_level(input logic active, input logic act_high);
    return act_high ? active : ~active;
  endfunction

endpackage

// File: rtl/sar_cctick_gen.sv
`timescale 1ns/1ps
module sar_cctick_gen #(
  parameter int SCLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic src_sel,
  input  logic osc_tick,
  input  logic sclk,
  output logic cc_tick
);
  localparam int DW = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SCLK_DIV - 1);

  logic          sclk_q;
  logic [DW-1:0] div_q;
  logic          sclk_rise;
  logic          div_wrap;

  assign sclk_rise = sclk & ~sclk_q;
  assign div_wrap  = (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      div_q  <= '0;
    end else begin
      sclk_q <= sclk;
      if (soft_rst) begin
        div_q <= '0;
      end else if (src_sel && sclk_rise) begin
        div_q <= div_wrap ? '0 : div_q + 1'b1;
      end
    end
  end

  assign cc_tick = src_sel ? (sclk_rise & div_wrap) : osc_tick;

  // R5: a divided serial tick needs a fresh sclk rise, so two ticks never abut
  a_r5_no_abutting_serial_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && cc_tick && !soft_rst) |=> !(src_sel && cc_tick));

  // R5: in serial mode a tick only ever coincides with a rising sclk edge
  a_r5_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && cc_tick) |-> (sclk && !sclk_q));

endmodule

// File: rtl/sar_phase_ctrl.sv
`timescale 1ns/1ps
module sar_phase_ctrl
  import sar_seq_pkg::*;
#(
  parameter int CONV_LEN = 18,
  parameter int ACQ_MIN  = 3,
  parameter int RES_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cc_tick,
  input  logic             auto_mode,
  input  logic             start_n,
  input  logic [RES_W-1:0] result_in,
  output logic             sample_en,
  output logic             convert_en,
  output logic             conv_done,
  output logic [RES_W-1:0] result_o
);
  localparam int CW = $clog2(CONV_LEN);
  localparam int AW = $clog2(ACQ_MIN + 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_LEN - 1);

  seq_phase_e       phase_q;
  logic [CW-1:0]    conv_q;
  logic [AW-1:0]    acq_q;
  logic [RES_W-1:0] res_q;

  logic acq_ok;
  logic trig_w;
  logic go_w;
  logic end_w;

  assign acq_ok = window_met(32'(acq_q), ACQ_MIN);
  assign trig_w = auto_mode | ~start_n;
  assign go_w   = cc_tick && (phase_q == PH_ACQ)  && acq_ok && trig_w;
  assign end_w  = cc_tick && (phase_q == PH_CONV) && (conv_q == CONV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ACQ;
      conv_q  <= '0;
      acq_q   <= '0;
      res_q   <= '0;
    end else if (soft_rst) begin
      phase_q <= PH_ACQ;
      conv_q  <= '0;
      acq_q   <= '0;
    end else begin
      case (phase_q)
        PH_ACQ: begin
          if (go_w) begin
            phase_q <= PH_CONV;
            conv_q  <= '0;
          end else if (cc_tick && !acq_ok) begin
            acq_q <= acq_q + 1'b1;
          end
        end
        default: begin
          if (end_w) begin
            phase_q <= PH_ACQ;
            acq_q   <= '0;
            res_q   <= result_in;
          end else if (cc_tick) begin
            conv_q <= conv_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign sample_en  = (phase_q == PH_ACQ);
  assign convert_en = (phase_q == PH_CONV);
  assign conv_done  = end_w;
  assign result_o   = res_q;

  // Independent tick counters that watch the outputs, used only by the checks below.
  logic [7:0] chk_conv_ticks;
  logic [7:0] chk_acq_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_conv_ticks <= '0;
      chk_acq_ticks  <= '0;
    end else begin
      if (!convert_en || soft_rst) chk_conv_ticks <= '0;
      else if (cc_tick && chk_conv_ticks != 8'hFF) chk_conv_ticks <= chk_conv_ticks + 8'd1;
      if (!sample_en || soft_rst) chk_acq_ticks <= '0;
      else if (cc_tick && chk_acq_ticks != 8'hFF) chk_acq_ticks <= chk_acq_ticks + 8'd1;
    end
  end

  // R1: every conversion that ends normally spans exactly CONV_LEN ticks
  a_r1_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(convert_en) && !$past(soft_rst)) |-> (chk_conv_ticks == 8'(CONV_LEN)));

  // R2: sampling lasts at least ACQ_MIN ticks before a conversion
  a_r2_acq_minimum: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convert_en) |-> (chk_acq_ticks >= 8'(ACQ_MIN)));

  // R3 and R4: a met window plus a trigger on a tick starts a conversion
  a_r3_r4_trigger_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_tick && sample_en && acq_ok && (auto_mode || !start_n) && !soft_rst) |=> convert_en);

  // R10: a running conversion is not cut short by any start request
  a_r10_conv_not_disturbed: assert property (@(posedge clk) disable iff (!rst_n)
    (convert_en && !end_w && !soft_rst) |=> (convert_en && $stable(result_o)));

  // R12: the result word is captured on the ending tick
  a_r12_result_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (end_w && !soft_rst) |=> (result_o == $past(result_in)));

endmodule

// File: rtl/sar_status_drv.sv
`timescale 1ns/1ps
module sar_status_drv
  import sar_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic int_mode,
  input  logic act_high,
  input  logic busy,
  input  logic conv_done,
  input  logic cs_n,
  output logic status_o
);
  logic cs_q;
  logic int_q;
  logic cs_fall;
  logic active_w;

  assign cs_fall = cs_q & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      int_q <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (soft_rst)       int_q <= 1'b0;
      else if (conv_done) int_q <= 1'b1;
      else if (cs_fall)   int_q <= 1'b0;
    end
  end

  assign active_w = int_mode ? int_q : busy;
  assign status_o = pin_level(active_w, act_high);

  // R7: a pending interrupt persists until a read frame opens
  a_r7_int_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q && !cs_fall && !soft_rst) |=> int_q);

  // R7: the end of a conversion raises the interrupt
  a_r7_int_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !soft_rst) |=> int_q);

  // R8: chip select falling clears the interrupt
  a_r8_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !conv_done) |=> !int_q);

  // R11: software reset drops a pending interrupt
  a_r11_soft_clears_int: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !int_q);

endmodule

// File: rtl/sar_seq_top.sv
`timescale 1ns/1ps
module sar_seq_top #(
  parameter int CONV_LEN = 18,
  parameter int ACQ_MIN  = 3,
  parameter int RES_W    = 12,
  parameter int SCLK_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             clk_src_sel,
  input  logic             osc_tick,
  input  logic             sclk,
  input  logic             auto_mode,
  input  logic             start_n,
  input  logic             stat_int_mode,
  input  logic             stat_act_high,
  input  logic             cs_n,
  input  logic [RES_W-1:0] result_in,
  output logic             sample_en,
  output logic             convert_en,
  output logic             status_o,
  output logic [RES_W-1:0] result_o
);
  logic cc_tick;
  logic conv_done;

  sar_cctick_gen #(.SCLK_DIV(SCLK_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .src_sel  (clk_src_sel),
    .osc_tick (osc_tick),
    .sclk     (sclk),
    .cc_tick  (cc_tick)
  );

  sar_phase_ctrl #(.CONV_LEN(CONV_LEN), .ACQ_MIN(ACQ_MIN), .RES_W(RES_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .cc_tick    (cc_tick),
    .auto_mode  (auto_mode),
    .start_n    (start_n),
    .result_in  (result_in),
    .sample_en  (sample_en),
    .convert_en (convert_en),
    .conv_done  (conv_done),
    .result_o   (result_o)
  );

  sar_status_drv u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .int_mode  (stat_int_mode),
    .act_high  (stat_act_high),
    .busy      (convert_en),
    .conv_done (conv_done),
    .cs_n      (cs_n),
    .status_o  (status_o)
  );

  // R11: software reset lands the sequencer in sampling
  a_r11_soft_to_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (sample_en && !convert_en));

  // R6 and R9: in busy-flag mode the pin reflects a running conversion at the chosen level
  a_r6_busy_level: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_int_mode |-> (status_o == (convert_en ~^ stat_act_high)));

  // sampling and converting never overlap
  a_r1_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sample_en, convert_en}));

endmodule

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        clk_src_sel = 1'b0;
  logic        osc_tick = 1'b0;
  logic        sclk = 1'b0;
  logic        auto_mode = 1'b0;
  logic        start_n = 1'b1;
  logic        stat_int_mode = 1'b0;
  logic        stat_act_high = 1'b0;
  logic        cs_n = 1'b1;
  logic [11:0] result_in = 12'h000;
  logic        sample_en;
  logic        convert_en;
  logic        status_o;
  logic [11:0] result_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sar_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clk_src_sel(clk_src_sel),
    .osc_tick(osc_tick), .sclk(sclk), .auto_mode(auto_mode), .start_n(start_n),
    .stat_int_mode(stat_int_mode), .stat_act_high(stat_act_high), .cs_n(cs_n),
    .result_in(result_in), .sample_en(sample_en), .convert_en(convert_en),
    .status_o(status_o), .result_o(result_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) osc_tick = 1'b1;
      @(negedge clk) osc_tick = 1'b0;
    end
  endtask

  task automatic sclk_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sclk = 1'b1;
      @(negedge clk) sclk = 1'b0;
    end
  endtask

  task automatic do_soft_rst;
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
  endtask

  // manual conversion: start low until converting, then 18 ticks to finish
  task automatic run_conv(input logic [11:0] word);
    result_in = word;
    start_n = 1'b0;
    for (int i = 0; i < 8 && !convert_en; i++) tk(1);
    start_n = 1'b1;
    tk(18);
  endtask

  task automatic t_reset;
    chk("R9 reset sample_en", sample_en, 1);
    chk("R9 reset convert_en", convert_en, 0);
    chk("R9 reset status inactive-high", status_o, 1);
    chk("R12 reset result", result_o, 0);
  endtask

  task automatic t_manual;
    tk(5);
    chk("R3 no start keeps sampling", sample_en, 1);
    start_n = 1'b0;
    tk(1);
    chk("R3 start begins conversion", convert_en, 1);
    chk("R6 busy status active low", status_o, 0);
    start_n = 1'b1;
    result_in = 12'hA5C;
    tk(17);
    chk("R1 still converting at tick 17", convert_en, 1);
    chk("R6 status held during conversion", status_o, 0);
    tk(1);
    chk("R1 conversion ends at tick 18", sample_en, 1);
    chk("R6 status inactive after end", status_o, 1);
    chk("R12 result captured", result_o, 12'hA5C);
    result_in = 12'h111;
    tk(1);
    chk("R12 result held", result_o, 12'hA5C);
  endtask

  task automatic t_acq_ignore;
    do_soft_rst();
    start_n = 1'b0;
    tk(2);
    chk("R2 sampling after 2 ticks", sample_en, 1);
    tk(1);
    chk("R2 converts on 3rd tick", convert_en, 1);
    tk(10);
    chk("R10 start during conversion ignored", convert_en, 1);
    tk(7);
    chk("R10 conversion still 18 ticks", convert_en, 1);
    start_n = 1'b1;
    tk(1);
    chk("R10 conversion ended normally", sample_en, 1);
    tk(3);
    chk("R3 start high keeps sampling", sample_en, 1);
  endtask

  task automatic t_auto;
    do_soft_rst();
    auto_mode = 1'b1;
    tk(2);
    chk("R4 auto sampling 2 ticks", sample_en, 1);
    tk(1);
    chk("R4 auto starts on 3rd tick", convert_en, 1);
    tk(18);
    chk("R4 auto back to sampling", sample_en, 1);
    tk(2);
    chk("R4 auto window not yet met", sample_en, 1);
    tk(1);
    chk("R4 auto re-triggers", convert_en, 1);
    tk(4);
    do_soft_rst();
    chk("R11 soft reset aborts conversion", convert_en, 0);
    chk("R11 soft reset status inactive", status_o, 1);
    auto_mode = 1'b0;
  endtask

  task automatic t_int;
    stat_int_mode = 1'b1;
    do_soft_rst();
    chk("R7 int inactive at start", status_o, 1);
    start_n = 1'b0;
    tk(3);
    start_n = 1'b1;
    chk("R7 int inactive while converting", status_o, 1);
    tk(18);
    chk("R7 int active after end", status_o, 0);
    repeat (5) @(negedge clk);
    chk("R7 int stays active", status_o, 0);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R8 cs fall clears int", status_o, 1);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R8 stays clear", status_o, 1);
  endtask

  task automatic t_polarity;
    stat_act_high = 1'b1;
    @(negedge clk);
    chk("R9 active-high inactive level", status_o, 0);
    run_conv(12'h3C7);
    chk("R9 active-high pending int", status_o, 1);
    chk("R12 second capture", result_o, 12'h3C7);
    do_soft_rst();
    chk("R11 soft reset clears int", status_o, 0);
    stat_int_mode = 1'b0;
    start_n = 1'b0;
    tk(3);
    start_n = 1'b1;
    chk("R9 busy active-high", status_o, 1);
    tk(18);
    stat_act_high = 1'b0;
  endtask

  task automatic t_sclk;
    do_soft_rst();
    clk_src_sel = 1'b1;
    start_n = 1'b0;
    tk(4);
    chk("R5 osc tick ignored in serial mode", sample_en, 1);
    sclk_pulses(5);
    chk("R5 five sclk rises give 2 ticks", sample_en, 1);
    sclk_pulses(1);
    chk("R5 sixth sclk rise gives 3rd tick", convert_en, 1);
    start_n = 1'b1;
    sclk_pulses(35);
    chk("R5 35 rises less than 18 ticks", convert_en, 1);
    sclk_pulses(1);
    chk("R5 36th rise ends conversion", sample_en, 1);
    clk_src_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_manual();
    t_acq_ignore();
    t_auto();
    t_int();
    t_polarity();
    t_sclk();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule